// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block keeps the clock-mode control word of a processor subsystem. The word chooses the CPU clock source and its division ratio. There are four sources: the main oscillator, the sub oscillator, an on-chip oscillator and a PLL. Software writes the whole control word in one write. The block compares the requested word with the current one. It accepts the write only if the move is a permitted mode transition. Otherwise it rejects the write, keeps the old word, raises a one-cycle reject pulse and sets a sticky error flag. Reading status clears the error flag.

On an accepted write the block first applies interlocks that pin some bits. It then drives a source select, a divide code and a mode code. It also makes a CPU tick enable: a behavioural divider counts the tick strobes of the active source. A switch to the main or the sub oscillator completes only once that oscillator reports that it is stable. Until then the previous source stays active and a pending flag is raised.

Control word layout (bit positions): [0] main stop, [1] sub select, [2] divide-by-8, [4:3] ratio field, [5] on-chip oscillator select, [6] sub oscillator enable, [7] high drive, [8] PLL on, [9] PLL select, [10] two-wait select, [11] stop-detect enable. Source codes: 0 main, 1 sub, 2 on-chip, 3 PLL. Divide codes: 0 to 4 mean divide by 1, 2, 4, 8 and 16.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the control word is 0x084 (divide-by-8 and high drive set). The main source is active with divide code 3. The error flag, reject pulse and pending flag are all 0.
- R2: For the main or on-chip source, the divide code is 3 when bit [2] is 1. Otherwise field [4:3] gives the code: 00→0, 01→1, 10→2, 11→4. The CPU tick then fires once per 2^code source ticks.
- R3: The source code is 3 when bits [8] and [9] are both 1. Otherwise it is 1 when bit [1] is 1, 2 when bit [5] is 1, and 0 in all other cases. Sub and PLL sources use divide code 0. The mode code is 6 for PLL operation.
- R4: A write that changes both field [4:3] and bit [2] is rejected.
- R5: While bit [11] is 1, a write that changes any of bits [0] to [5], [8] or [9] is rejected.
- R6: When bit [5] is 0 and bit [0] is 1 in the resulting word, bits [2] and [7] are held at 1. Writes of 0 to them are ignored without a reject.
- R7: Bit [0] may rise only while bit [1] or bit [5] is currently 1. A word with bit [0] set and neither bit [1] nor bit [5] set is rejected.
- R8: Bit [1] may rise only while bit [6] is already 1 and bit [8] is 0. Any word with bit [1] set and bit [6] clear is rejected.
- R9: Clearing bit [5] to return to the main oscillator is rejected unless bit [2] is already 1.
- R10: Bit [9] set with bit [8] clear is rejected. Bit [8] may rise only from high-speed main mode (divide code 0). While bit [8] is 1, before or after the write, a change of bits [0] to [5] is rejected.
- R11: Bit [10] may change only while bit [8] is 0. If the PLL frequency parameter is above the wait limit, raising bit [8] requires bit [10] to be 1.
- R12: A rejected write leaves the word unchanged, pulses the reject output for one cycle and sets the error flag. The error flag stays set until a status read clears it.
- R13: A switch to the main or sub source waits for that oscillator's stable input. While it waits, the pending flag is 1 and the old source and divide code remain active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 12 | Requested control word |
| stat_rd | input | 1 | Status read strobe, clears error flag |
| main_stable | input | 1 | Main oscillator stable |
| sub_stable | input | 1 | Sub oscillator stable |
| src_tick | input | 4 | Tick strobe per source (main, sub, on-chip, PLL) |
| ctl_q | output | 12 | Current control word |
| src_sel | output | 2 | Active source code |
| div_sel | output | 3 | Active divide code |
| mode | output | 3 | Mode code derived from the control word |
| cpu_tick | output | 1 | Divided CPU tick enable |
| switch_pending | output | 1 | Source switch waiting for stability |
| err_flag | output | 1 | Sticky reject flag |
| reject_pulse | output | 1 | One-cycle reject indication |

## Verification
The bench pushes the word into several states where the pinned bits act. It tries to clear them directly and also changes the ratio field at the same time. A design that checked legality before applying the pinned values would then accept an illegal combined change or flag a harmless write. The bench attempts PLL entry from middle speed, without two waits, and with an orphan PLL select. A careless design would run the PLL at the wrong ratio or with too few waits. It also holds the stable inputs low during switches, where a design that switched early would report the new source too soon. A long run of random bit flips checks every accept and reject decision against a model of the transition rules.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   localparam int CTL_W = 12;
   localparam int N_SRC = 4;
   localparam int SRC_W = $clog2(N_SRC);
   localparam int DIV_W = 3;
   localparam int MODE_W = 3;

   typedef struct packed {
      logic       osden;   // [11] stop-detect enable
      logic       wait2;   // [10] two-wait select
      logic       pllsel;  // [9]
      logic       pllon;   // [8]
      logic       drvhi;   // [7]
      logic       suben;   // [6]
      logic       rocsel;  // [5]
      logic [1:0] ratio;   // [4:3]
      logic       div8;    // [2]
      logic       subsel;  // [1]
      logic       mstop;   // [0]
   } ctl_t;

   localparam logic [CTL_W-1:0] CTL_RESET = 12'h084;

   localparam logic [SRC_W-1:0] SRC_MAIN = 2'd0;
   localparam logic [SRC_W-1:0] SRC_SUB  = 2'd1;
   localparam logic [SRC_W-1:0] SRC_ROC  = 2'd2;
   localparam logic [SRC_W-1:0] SRC_PLL  = 2'd3;

   localparam logic [MODE_W-1:0] MODE_HIGH   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_MID    = 3'd1;
   localparam logic [MODE_W-1:0] MODE_LOW    = 3'd2;
   localparam logic [MODE_W-1:0] MODE_LOW_LP = 3'd3;
   localparam logic [MODE_W-1:0] MODE_ROC    = 3'd4;
   localparam logic [MODE_W-1:0] MODE_ROC_LP = 3'd5;
   localparam logic [MODE_W-1:0] MODE_PLL    = 3'd6;

   function automatic logic [SRC_W-1:0] target_src(ctl_t c);
      if (c.pllon && c.pllsel) return SRC_PLL;
      else if (c.subsel)       return SRC_SUB;
      else if (c.rocsel)       return SRC_ROC;
      else                     return SRC_MAIN;
   endfunction

   function automatic logic [DIV_W-1:0] div_code(ctl_t c);
      logic [DIV_W-1:0] code;
      if ((c.pllon && c.pllsel) || c.subsel) code = 3'd0;
      else if (c.div8)                       code = 3'd3;
      else begin
         case (c.ratio)
            2'b00:   code = 3'd0;
            2'b01:   code = 3'd1;
            2'b10:   code = 3'd2;
            default: code = 3'd4;
         endcase
      end
      return code;
   endfunction

   function automatic logic [MODE_W-1:0] mode_of(ctl_t c);
      if (c.pllon && c.pllsel)      return MODE_PLL;
      else if (c.subsel)            return c.mstop ? MODE_LOW_LP : MODE_LOW;
      else if (c.rocsel)            return c.mstop ? MODE_ROC_LP : MODE_ROC;
      else if (div_code(c) == 3'd0) return MODE_HIGH;
      else                          return MODE_MID;
   endfunction

endpackage

// File: rtl/clkmode_legal.sv
module clkmode_legal
   import clkmode_pkg::*;
#(
   parameter int PLL_FREQ_KHZ   = 20000,
   parameter int WAIT_LIMIT_KHZ = 16000
) (
   input  ctl_t cur,
   input  ctl_t req,
   output ctl_t nxt,
   output logic reject
);

   logic need_wait;

   generate
      if (PLL_FREQ_KHZ > WAIT_LIMIT_KHZ) begin : g_fast_pll
         assign need_wait = 1'b1;
      end else begin : g_slow_pll
         assign need_wait = 1'b0;
      end
   endgenerate

   logic cur_high, base_chg, mode_chg;
   logic r_osd, r_both, r_stop, r_nosrc, r_sub, r_roc, r_pll, r_wait;

   always_comb begin
      nxt = req;
      // pinned bits: no on-chip oscillator and main stopped
      if (!req.rocsel && req.mstop) begin
         nxt.div8  = 1'b1;
         nxt.drvhi = 1'b1;
      end

      cur_high = !cur.subsel && !cur.rocsel && !cur.div8 &&
                 (cur.ratio == 2'b00) && !cur.mstop;
      base_chg = {nxt.mstop, nxt.subsel, nxt.div8, nxt.ratio, nxt.rocsel} !=
                 {cur.mstop, cur.subsel, cur.div8, cur.ratio, cur.rocsel};
      mode_chg = base_chg || ({nxt.pllon, nxt.pllsel} != {cur.pllon, cur.pllsel});

      r_osd   = cur.osden && mode_chg;
      r_both  = (nxt.ratio != cur.ratio) && (nxt.div8 != cur.div8);
      r_stop  = nxt.mstop && !cur.mstop && !(cur.subsel || cur.rocsel);
      r_nosrc = nxt.mstop && !nxt.subsel && !nxt.rocsel;
      r_sub   = (nxt.subsel && !cur.subsel && (!cur.suben || cur.pllon)) ||
                (nxt.subsel && !nxt.suben);
      r_roc   = cur.rocsel && !nxt.rocsel && !nxt.subsel && !cur.div8;
      r_pll   = (nxt.pllsel && !nxt.pllon) ||
                (nxt.pllon && !cur.pllon && !cur_high) ||
                ((cur.pllon || nxt.pllon) && base_chg);
      r_wait  = ((nxt.wait2 != cur.wait2) && cur.pllon) ||
                (need_wait && nxt.pllon && !cur.pllon && !nxt.wait2);

      reject = r_osd || r_both || r_stop || r_nosrc ||
               r_sub || r_roc || r_pll || r_wait;
   end

endmodule

// File: rtl/clkmode_switch.sv
module clkmode_switch
   import clkmode_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] tgt_src,
   input  logic [DIV_W-1:0] tgt_div,
   input  logic             main_stable,
   input  logic             sub_stable,
   output logic [SRC_W-1:0] act_src,
   output logic [DIV_W-1:0] act_div,
   output logic             pending
);

   logic ready;

   always_comb begin
      case (tgt_src)
         SRC_MAIN: ready = main_stable;
         SRC_SUB:  ready = sub_stable;
         default:  ready = 1'b1;
      endcase
      pending = (tgt_src != act_src);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src <= SRC_MAIN;
         act_div <= 3'd3;
      end else if (!pending || ready) begin
         act_src <= tgt_src;
         act_div <= tgt_div;
      end
   end

endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider
   import clkmode_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_tick,
   input  logic [SRC_W-1:0] sel,
   input  logic [DIV_W-1:0] div,
   output logic             cpu_tick
);

   logic [N_SRC-1:0] tick_vec;
   logic             tick_in, chg;
   logic [CNT_W-1:0] cnt, limit;
   logic [SRC_W-1:0] sel_q;
   logic [DIV_W-1:0] div_q;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_tick
         assign tick_vec[i] = src_tick[i] && (sel == SRC_W'(i));
      end
   endgenerate

   always_comb begin
      tick_in  = |tick_vec;
      chg      = (sel != sel_q) || (div != div_q);
      limit    = CNT_W'((32'd1 << div) - 32'd1);
      cpu_tick = tick_in && !chg && (cnt == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= SRC_MAIN;
         div_q <= 3'd3;
      end else if (chg) begin
         cnt   <= '0;
         sel_q <= sel;
         div_q <= div;
      end else if (tick_in) begin
         cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int PLL_FREQ_KHZ   = 20000,
   parameter int WAIT_LIMIT_KHZ = 16000,
   parameter int DIV_CNT_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   input  logic             stat_rd,
   input  logic             main_stable,
   input  logic             sub_stable,
   input  logic [N_SRC-1:0] src_tick,
   output logic [CTL_W-1:0] ctl_q,
   output logic [SRC_W-1:0] src_sel,
   output logic [DIV_W-1:0] div_sel,
   output logic [MODE_W-1:0] mode,
   output logic             cpu_tick,
   output logic             switch_pending,
   output logic             err_flag,
   output logic             reject_pulse
);

   generate
      if (PLL_FREQ_KHZ <= 0)    begin : g_bad_freq  $error("PLL_FREQ_KHZ must be positive");  end
      if (WAIT_LIMIT_KHZ <= 0)  begin : g_bad_limit $error("WAIT_LIMIT_KHZ must be positive"); end
      if (DIV_CNT_W < 4)        begin : g_bad_cnt   $error("DIV_CNT_W must hold a count of 15"); end
   endgenerate

   ctl_t ctl_r, nxt;
   logic reject;

   clkmode_legal #(
      .PLL_FREQ_KHZ  (PLL_FREQ_KHZ),
      .WAIT_LIMIT_KHZ(WAIT_LIMIT_KHZ)
   ) u_legal (
      .cur   (ctl_r),
      .req   (ctl_t'(wr_data)),
      .nxt   (nxt),
      .reject(reject)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_r        <= ctl_t'(CTL_RESET);
         reject_pulse <= 1'b0;
         err_flag     <= 1'b0;
      end else begin
         reject_pulse <= wr_en && reject;
         if (wr_en && !reject) ctl_r <= nxt;
         if (wr_en && reject)  err_flag <= 1'b1;
         else if (stat_rd)     err_flag <= 1'b0;
      end
   end

   clkmode_switch u_switch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tgt_src    (target_src(ctl_r)),
      .tgt_div    (div_code(ctl_r)),
      .main_stable(main_stable),
      .sub_stable (sub_stable),
      .act_src    (src_sel),
      .act_div    (div_sel),
      .pending    (switch_pending)
   );

   clkmode_divider #(.CNT_W(DIV_CNT_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_tick(src_tick),
      .sel     (src_sel),
      .div     (div_sel),
      .cpu_tick(cpu_tick)
   );

   assign ctl_q = ctl_r;
   assign mode  = mode_of(ctl_r);

endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
   import clkmode_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             main_stable,
   input logic             sub_stable,
   input logic [CTL_W-1:0] ctl_q,
   input logic [SRC_W-1:0] src_sel,
   input logic [DIV_W-1:0] div_sel,
   input logic             switch_pending,
   input logic             err_flag,
   input logic             reject_pulse
);

   p_pinned_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[0] && !ctl_q[5]) |-> (ctl_q[2] && ctl_q[7]));

   p_no_joint_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((ctl_q[4:3] != $past(ctl_q[4:3])) && (ctl_q[2] != $past(ctl_q[2]))));

   p_osd_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_q[11]) |-> ({ctl_q[9:8], ctl_q[5:0]} == $past({ctl_q[9:8], ctl_q[5:0]})));

   p_wait_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_q[8]) |-> (ctl_q[10] == $past(ctl_q[10])));

   p_reject_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reject_pulse |-> ((ctl_q == $past(ctl_q)) && err_flag));

   p_sub_wait_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[1] && !sub_stable && switch_pending) |=> $stable(src_sel));

   p_main_wait_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[1] && !ctl_q[5] && !ctl_q[9] && !main_stable && switch_pending)
      |=> $stable(src_sel));

   p_undivided_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_sel == SRC_SUB) || (src_sel == SRC_PLL)) |-> (div_sel == 3'd0));

   p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      div_sel <= 3'd4);

endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (.*);

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_data = '0;
   logic        stat_rd = 1'b0;
   logic        main_stable = 1'b1;
   logic        sub_stable = 1'b1;
   logic [3:0]  src_tick = 4'hF;
   logic [11:0] ctl_q;
   logic [1:0]  src_sel;
   logic [2:0]  div_sel;
   logic [2:0]  mode;
   logic        cpu_tick, switch_pending, err_flag, reject_pulse;

   int n_chk = 0;
   int n_fail = 0;
   logic [11:0] m_ctl;
   logic        m_err;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   clkmode_ctrl u_dut (.*);

   // bit positions of the control word
   localparam int B_MSTOP = 0, B_SUB = 1, B_DIV8 = 2, B_ROC = 5, B_SUBEN = 6,
                  B_DRV = 7, B_PLLON = 8, B_PLLSEL = 9, B_WAIT = 10, B_OSD = 11;

   function automatic logic [12:0] bench_apply(input logic [11:0] c, input logic [11:0] r);
      logic [11:0] n;
      logic rej, hs, base;
      n = r;
      if (!r[B_ROC] && r[B_MSTOP]) begin n[B_DIV8] = 1'b1; n[B_DRV] = 1'b1; end
      hs = !c[B_SUB] && !c[B_ROC] && !c[B_DIV8] && c[4:3] == 2'b00 && !c[B_MSTOP];
      base = (n[5:0] != c[5:0]);
      rej = 1'b0;
      if (c[B_OSD] && (base || n[9:8] != c[9:8])) rej = 1'b1;                  // R5
      if (n[4:3] != c[4:3] && n[B_DIV8] != c[B_DIV8]) rej = 1'b1;               // R4
      if (n[B_MSTOP] && !c[B_MSTOP] && !(c[B_SUB] || c[B_ROC])) rej = 1'b1;     // R7
      if (n[B_MSTOP] && !n[B_SUB] && !n[B_ROC]) rej = 1'b1;                     // R7
      if (n[B_SUB] && !c[B_SUB] && (!c[B_SUBEN] || c[B_PLLON])) rej = 1'b1;     // R8
      if (n[B_SUB] && !n[B_SUBEN]) rej = 1'b1;                                  // R8
      if (c[B_ROC] && !n[B_ROC] && !n[B_SUB] && !c[B_DIV8]) rej = 1'b1;         // R9
      if (n[B_PLLSEL] && !n[B_PLLON]) rej = 1'b1;                               // R10
      if (n[B_PLLON] && !c[B_PLLON] && !hs) rej = 1'b1;                         // R10
      if ((c[B_PLLON] || n[B_PLLON]) && base) rej = 1'b1;                       // R10
      if (n[B_WAIT] != c[B_WAIT] && c[B_PLLON]) rej = 1'b1;                     // R11
      if (n[B_PLLON] && !c[B_PLLON] && !n[B_WAIT]) rej = 1'b1;                  // R11 (20 MHz PLL)
      return {rej, rej ? c : n};
   endfunction

   function automatic int exp_src(input logic [11:0] c);
      if (c[B_PLLON] && c[B_PLLSEL]) return 3;
      if (c[B_SUB]) return 1;
      if (c[B_ROC]) return 2;
      return 0;
   endfunction

   function automatic int exp_div(input logic [11:0] c);
      if ((c[B_PLLON] && c[B_PLLSEL]) || c[B_SUB]) return 0;
      if (c[B_DIV8]) return 3;
      case (c[4:3])
         2'b00: return 0;
         2'b01: return 1;
         2'b10: return 2;
         default: return 4;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input string tag, input logic [11:0] d);
      logic [12:0] e;
      e = bench_apply(m_ctl, d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (e[12]) m_err = 1'b1;
      m_ctl = e[11:0];
      chk({tag, " word"}, int'(ctl_q), int'(m_ctl));
      chk({tag, " reject R12"}, int'(reject_pulse), int'(e[12]));
      chk({tag, " error R12"}, int'(err_flag), int'(m_err));
   endtask

   task automatic check_src(input string tag);
      @(negedge clk);
      chk({tag, " source R3"}, int'(src_sel), exp_src(m_ctl));
      chk({tag, " divide R2"}, int'(div_sel), exp_div(m_ctl));
   endtask

   task automatic count_ticks(input string tag, input int exp);
      int n = 0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         if (cpu_tick) n++;
      end
      chk(tag, n, exp);
   endtask

   task automatic read_status();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      m_err = 1'b0;
      chk("status read clears error R12", int'(err_flag), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      m_ctl = 12'h084;
      m_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("reset word R1", int'(ctl_q), 'h084);
      chk("reset source R1", int'(src_sel), 0);
      chk("reset divide R1", int'(div_sel), 3);
      chk("reset error R1", int'(err_flag), 0);
      chk("reset pending R1", int'(switch_pending), 0);
      count_ticks("tick rate /8 R2", 4);

      // R2 ratio walk
      do_write("ratio 01 under div8 R2", 12'h08C); check_src("ratio 01 under div8");
      do_write("clear div8 R2", 12'h088);           check_src("clear div8");
      count_ticks("tick rate /2 R2", 16);
      do_write("ratio 11 R2", 12'h098);             check_src("ratio 11");
      count_ticks("tick rate /16 R2", 2);
      do_write("joint ratio and div8 R4", 12'h084);
      read_status();
      do_write("back to high speed R2", 12'h080);   check_src("high speed");
      count_ticks("tick rate /1 R2", 32);

      // R10 R11 PLL
      do_write("pll without wait R11", 12'h380);
      do_write("set wait R11", 12'h480);
      do_write("enter pll R10", 12'h780);           check_src("pll mode");
      chk("pll mode code R3", int'(mode), 6);
      do_write("wait change in pll R11", 12'h380);
      do_write("ratio change in pll R10", 12'h788);
      do_write("leave pll R10", 12'h480);
      do_write("select without pll on R10", 12'h680);
      do_write("middle speed R2", 12'h488);
      do_write("pll from middle speed R10", 12'h788);
      do_write("back to high R2", 12'h480);         check_src("after pll");

      // R8 R13 sub clock
      sub_stable = 1'b0;
      do_write("sub without enable R8", 12'h482);
      do_write("sub enable R8", 12'h4C0);
      do_write("sub select R8", 12'h4C2);
      chk("pending while sub unstable R13", int'(switch_pending), 1);
      repeat (3) @(negedge clk);
      chk("old source held R13", int'(src_sel), 0);
      sub_stable = 1'b1;
      @(negedge clk);
      chk("sub source after stable R13", int'(src_sel), 1);
      chk("pending cleared R13", int'(switch_pending), 0);
      do_write("drop enable while sub R8", 12'h482);

      // R6 R7 low power
      do_write("main stop from sub R7", 12'h4C3);
      chk("pinned word R6", int'(ctl_q), 'h4C7);
      do_write("clear div8 ignored R6", 12'h4C3);
      do_write("clear drive ignored R6", 12'h447);
      do_write("restart main R7", 12'h4C6);
      main_stable = 1'b0;
      do_write("sub to main R13", 12'h4C4);
      repeat (2) @(negedge clk);
      chk("main wait holds sub R13", int'(src_sel), 1);
      chk("main wait pending R13", int'(switch_pending), 1);
      main_stable = 1'b1;
      check_src("main after stable R13");
      do_write("main stop from main R7", 12'h4C5);

      // R9 on-chip oscillator
      do_write("enter roc R3", 12'h4E4);            check_src("roc /8");
      do_write("roc /1 R2", 12'h4E0);               check_src("roc /1");
      do_write("main stop in roc R7", 12'h4E1);
      do_write("no source R7", 12'h4C1);
      do_write("restart main in roc R7", 12'h4E0);
      do_write("leave roc without div8 R9", 12'h4C0);
      do_write("div8 in roc R9", 12'h4E4);
      do_write("leave roc with div8 R9", 12'h4C4);  check_src("main from roc");

      // R5 stop detect
      do_write("set stop detect R5", 12'hCC4);
      do_write("ratio under stop detect R5", 12'hCCC);
      do_write("clear stop detect R5", 12'h4C4);
      read_status();

      // random bit flips
      for (int it = 0; it < 600; it++) begin
         int a, b;
         a = $urandom_range(0, 11);
         b = $urandom_range(0, 11);
         do_write("random transition R12", m_ctl ^ (12'd1 << a) ^ (12'd1 << b));
         check_src("random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule